// File: doc/BRIEF.md
# Runtime-Configurable Stream Crossbar

This block switches pixel streams between producers and consumers inside a vision pipeline. It has `N_IN` stream inputs and `N_OUT` stream outputs. Each stream is a data word plus a valid flag. Software chooses which input feeds each output by writing a connection matrix through a small memory-mapped register port. Changing the matrix needs no rebuild of the hardware.

The matrix is stored one column per output. Bit `i` of column `j` connects input `i` to output `j`. A column with exactly one set bit routes that input to the output through a single register stage. A column with no set bits, or with more than one, blocks its output. Several columns may select the same input, so one stream can feed several sub-pipelines at once. Different columns may also select different inputs, which gives independent parallel pipelines.

A column is written as one word in a single bus cycle. The new selection is therefore applied to the whole column at one clock edge. A sticky error flag records any write that stores a column which is not one-hot.

Top module: `stream_xbar`

## Requirements
- R1: Data and valid go from an input to a routed output with a latency of exactly one clock cycle. The output does not change before the next rising edge.
- R2: When column `j` holds only bit `i`, output `j` carries input `i`'s data word and valid flag.
- R3: Several outputs may select the same input. Each of those outputs then carries that input's stream in the same cycle.
- R4: An output whose column holds no set bit drives valid 0 and data 0 on the cycle after each edge, whatever the inputs do.
- R5: An output whose column holds more than one set bit drives valid 0 and data 0. Any write that stores a column whose count of set bits is not exactly one sets the error flag.
- R6: The error flag is sticky and reads as bit 0 at address `N_OUT`. Writing 1 to bit 0 of that address clears it. Writing 0 there leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R7: After a synchronous active-high reset, every column is zero, every output valid and data is 0, and the error flag is 0.
- R8: Asserting `cfg_rd` at address `k < N_OUT` returns column `k` on `cfg_rdata` one cycle later. Reads return the stored matrix cell by cell.
- R9: A column written at clock edge E is first used at edge E+1. The output sampled at edge E still uses the old column. No output ever sees a mix of the old and new selection.
- R10: Writes to addresses above `N_OUT` change nothing. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | AW = clog2(N_OUT+1) | Register address: column index, or `N_OUT` for the status register |
| cfg_wdata | input | N_IN | Write data (a column, or the status clear bit) |
| cfg_rdata | output | N_IN | Registered read data |
| in_valid | input | N_IN | Valid flag of each input stream |
| in_data | input | N_IN*DW | Input data words, with input `i` in bits `[i*DW +: DW]` |
| out_valid | output | N_OUT | Registered valid flag of each output stream |
| out_data | output | N_OUT*DW | Registered output data, with output `j` in bits `[j*DW +: DW]` |

## Verification
The assertions check, on every cycle, the following rules:
- a badly formed column blocks its output on the next cycle;
- a one-hot column passes the selected input's valid flag one cycle later;
- the error flag rises after a bad write and stays up until a clear;
- a column write lands in storage intact.

Some behaviours can only be shown by the bench's scenarios:
- the data words seen at the ports for the routing patterns (identity, fan-out, permutation, empty and multi-bit columns);
- the exact edge at which a rewritten column takes over;
- that undecoded addresses are ignored;
- the full reset and readback state.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ONE  = 2'd1,
    SEL_MANY = 2'd2
  } sel_kind_e;

  // Classifies a routing column (up to 32 inputs, zero-extended).
  function automatic sel_kind_e classify_col(input logic [31:0] col);
    int unsigned n;
    n = $countones(col);
    if (n == 0)      return SEL_NONE;
    else if (n == 1) return SEL_ONE;
    else             return SEL_MANY;
  endfunction

endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
  import xbar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int AW    = $clog2(N_OUT + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr,
  input  logic                        cfg_rd,
  input  logic [AW-1:0]               cfg_addr,
  input  logic [N_IN-1:0]             cfg_wdata,
  output logic [N_IN-1:0]             cfg_rdata,
  output logic [N_OUT-1:0][N_IN-1:0]  col_sel
);

  localparam int          CIW       = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam logic [AW-1:0] STAT_ADDR = AW'(N_OUT);

  logic [N_OUT-1:0][N_IN-1:0] matrix_q;
  logic                       err_q;
  logic                       hit_col;
  logic                       hit_stat;
  logic [CIW-1:0]             col_idx;
  logic                       err_set;
  logic                       err_clr;
  logic [N_IN-1:0]            rd_word;

  always_comb begin
    hit_col  = (cfg_addr < STAT_ADDR);
    hit_stat = (cfg_addr == STAT_ADDR);
    col_idx  = cfg_addr[CIW-1:0];
    err_set  = cfg_wr && hit_col && (classify_col(32'(cfg_wdata)) != SEL_ONE);
    err_clr  = cfg_wr && hit_stat && cfg_wdata[0];
    rd_word  = '0;
    if (hit_col)       rd_word    = matrix_q[col_idx];
    else if (hit_stat) rd_word[0] = err_q;
  end

  // Whole column replaced in one cycle: atomic per output.
  always_ff @(posedge clk) begin
    if (rst) begin
      matrix_q  <= '0;
      err_q     <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr && hit_col) matrix_q[col_idx] <= cfg_wdata;
      err_q <= err_set | (err_q & ~err_clr);
      if (cfg_rd) cfg_rdata <= rd_word;
    end
  end

  assign col_sel = matrix_q;

  p_bad_write_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_addr < STAT_ADDR) && ($countones(cfg_wdata) != 1)) |=> err_q);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(cfg_wr && (cfg_addr == STAT_ADDR) && cfg_wdata[0])) |=> err_q);

  p_col_write_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_addr < STAT_ADDR)) |=> (col_sel[$past(col_idx)] == $past(cfg_wdata)));

endmodule

// File: rtl/xbar_col_mux.sv
module xbar_col_mux
  import xbar_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int DW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_IN-1:0]           col,
  input  logic [N_IN-1:0][DW-1:0]   in_data,
  input  logic [N_IN-1:0]           in_valid,
  output logic [DW-1:0]             out_data,
  output logic                      out_valid
);

  sel_kind_e       kind;
  logic [DW-1:0]   pick_data;
  logic            pick_valid;

  always_comb begin
    kind       = classify_col(32'(col));
    pick_data  = '0;
    pick_valid = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (col[i]) begin
        pick_data  = pick_data | in_data[i];
        pick_valid = pick_valid | in_valid[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (kind != SEL_ONE)) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_data  <= pick_data;
      out_valid <= pick_valid;
    end
  end

  p_bad_col_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(col) != 1) |=> (!out_valid && (out_data == '0)));

  p_valid_passes_r1: assert property (@(posedge clk) disable iff (rst)
    (($countones(col) == 1) && ((col & in_valid) != '0)) |=> out_valid);

  p_idle_passes_r2: assert property (@(posedge clk) disable iff (rst)
    (($countones(col) == 1) && ((col & in_valid) == '0)) |=> !out_valid);

endmodule

// File: rtl/stream_xbar.sv
module stream_xbar #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DW    = 8,
  parameter int AW    = $clog2(N_OUT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [N_IN-1:0]       cfg_wdata,
  output logic [N_IN-1:0]       cfg_rdata,
  input  logic [N_IN-1:0]       in_valid,
  input  logic [N_IN*DW-1:0]    in_data,
  output logic [N_OUT-1:0]      out_valid,
  output logic [N_OUT*DW-1:0]   out_data
);

  logic [N_OUT-1:0][N_IN-1:0] col_sel;
  logic [N_IN-1:0][DW-1:0]    in_arr;
  logic [DW-1:0]              out_arr [N_OUT];

  assign in_arr = in_data;

  xbar_cfg_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .col_sel   (col_sel)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    xbar_col_mux #(.N_IN(N_IN), .DW(DW)) u_mux (
      .clk       (clk),
      .rst       (rst),
      .col       (col_sel[j]),
      .in_data   (in_arr),
      .in_valid  (in_valid),
      .out_data  (out_arr[j]),
      .out_valid (out_valid[j])
    );
    assign out_data[j*DW +: DW] = out_arr[j];
  end

endmodule

// File: tb/stream_xbar_test.sv
module stream_xbar_test;

  localparam int NI = 4;
  localparam int NO = 4;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NV = 6;

  // {col3,col2,col1,col0}[15:0], in_valid[3:0], in_data[31:0]
  localparam logic [51:0] VEC [NV] = '{
    {16'h8421, 4'hF,    32'h44332211},
    {16'h4444, 4'b0100, 32'hDDCCBBAA},
    {16'h2148, 4'b1010, 32'h0F1E2D3C},
    {16'h1101, 4'hF,    32'h11223344},
    {16'h8342, 4'hF,    32'hA5A55A5A},
    {16'h0000, 4'hF,    32'h99887766}
  };
  string VTAG [NV] = '{"R2", "R3", "R3", "R4", "R5", "R4"};

  logic          clk = 0;
  logic          rst = 1;
  logic          cfg_wr = 0, cfg_rd = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [NI-1:0] cfg_wdata = '0;
  logic [NI-1:0] cfg_rdata;
  logic [NI-1:0] in_valid = '0;
  logic [NI*DW-1:0] in_data = '0;
  logic [NO-1:0] out_valid;
  logic [NO*DW-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  stream_xbar #(.N_IN(NI), .N_OUT(NO), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [NI-1:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [NI-1:0] d);
    cfg_rd = 1; cfg_addr = a;
    step();
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  // Expected outputs derived from the routing rules R2..R5.
  task automatic model(input logic [15:0] cols, input logic [3:0] iv, input logic [31:0] id,
                       output logic [3:0] ev, output logic [31:0] ed);
    ev = '0; ed = '0;
    for (int j = 0; j < NO; j++) begin
      logic [3:0] c;
      c = cols[j*4 +: 4];
      if ($countones(c) == 1) begin
        for (int i = 0; i < NI; i++)
          if (c[i]) begin
            ev[j] = iv[i];
            ed[j*DW +: DW] = id[i*DW +: DW];
          end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NI-1:0] rd;
    logic [3:0]    ev;
    logic [31:0]   ed;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R7: reset state
    check("R7 valid", 64'(out_valid), 64'h0);
    check("R7 data", 64'(out_data), 64'h0);
    for (int k = 0; k < NO; k++) begin
      reg_read(AW'(k), rd);
      check("R7 column", 64'(rd), 64'h0);
    end
    reg_read(AW'(NO), rd);
    check("R7 status", 64'(rd), 64'h0);
    in_valid = 4'hF; in_data = 32'hCAFEBABE;
    step();
    check("R7 unconfigured valid", 64'(out_valid), 64'h0);
    check("R7 unconfigured data", 64'(out_data), 64'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      for (int j = 0; j < NO; j++) reg_write(AW'(j), VEC[v][36 + j*4 +: 4]);
      in_valid = VEC[v][35:32];
      in_data  = VEC[v][31:0];
      step();
      model(VEC[v][51:36], VEC[v][35:32], VEC[v][31:0], ev, ed);
      check({VTAG[v], " valid"}, 64'(out_valid), 64'(ev));
      check({VTAG[v], " data"}, 64'(out_data), 64'(ed));
    end

    // R6 / R5: sticky error
    reg_write(AW'(NO), 4'b0001);
    reg_read(AW'(NO), rd);
    check("R6 cleared", 64'(rd), 64'h0);
    reg_write(AW'(1), 4'b0110);
    reg_read(AW'(NO), rd);
    check("R5 error set", 64'(rd), 64'h1);
    reg_write(AW'(1), 4'b0010);
    reg_read(AW'(NO), rd);
    check("R6 sticky after good write", 64'(rd), 64'h1);
    reg_write(AW'(NO), 4'b0000);
    reg_read(AW'(NO), rd);
    check("R6 write 0 keeps", 64'(rd), 64'h1);
    reg_write(AW'(NO), 4'b0001);
    reg_read(AW'(NO), rd);
    check("R6 write 1 clears", 64'(rd), 64'h0);

    // R8: readback of every column
    reg_write(AW'(0), 4'b0100);
    reg_write(AW'(1), 4'b1000);
    reg_write(AW'(2), 4'b0001);
    reg_write(AW'(3), 4'b0010);
    reg_read(AW'(0), rd); check("R8 col0", 64'(rd), 64'h4);
    reg_read(AW'(1), rd); check("R8 col1", 64'(rd), 64'h8);
    reg_read(AW'(2), rd); check("R8 col2", 64'(rd), 64'h1);
    reg_read(AW'(3), rd); check("R8 col3", 64'(rd), 64'h2);

    // R10: undecoded addresses ignored
    reg_write(AW'(6), 4'hF);
    reg_write(AW'(7), 4'hF);
    reg_read(AW'(0), rd); check("R10 col0 intact", 64'(rd), 64'h4);
    reg_read(AW'(3), rd); check("R10 col3 intact", 64'(rd), 64'h2);
    reg_read(AW'(NO), rd); check("R10 status intact", 64'(rd), 64'h0);
    reg_read(AW'(6), rd); check("R10 read zero", 64'(rd), 64'h0);

    // R1: one-cycle latency on identity routing
    reg_write(AW'(0), 4'b0001);
    reg_write(AW'(1), 4'b0010);
    reg_write(AW'(2), 4'b0100);
    reg_write(AW'(3), 4'b1000);
    in_valid = 4'hF; in_data = 32'h01020304;
    step();
    check("R1 data after one edge", 64'(out_data), 64'h01020304);
    in_valid = 4'b0000; in_data = 32'hFFEEDDCC;
    #1;
    check("R1 no change before edge", 64'(out_data), 64'h01020304);
    check("R1 valid holds before edge", 64'(out_valid), 64'hF);
    step();
    check("R1 valid drop", 64'(out_valid), 64'h0);
    check("R1 data follows", 64'(out_data), 64'hFFEEDDCC);

    // R9: column change takes effect one edge after the write
    in_valid = 4'hF; in_data = 32'h04030201;
    step();
    cfg_wr = 1; cfg_addr = AW'(0); cfg_wdata = 4'b0010;
    step();
    cfg_wr = 0;
    check("R9 old column at write edge", 64'(out_data[7:0]), 64'h01);
    step();
    check("R9 new column next edge", 64'(out_data[7:0]), 64'h02);
    check("R9 other outputs untouched", 64'(out_data[31:8]), 64'h040302);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule